// File: doc/BRIEF.md
# Flash Write-Status Readback Generator

This block forms the word a parallel NOR flash returns to the host while an embedded program or erase is running, suspended or has just been refused. The program and erase engines, the suspend controller and the buffer-load logic report their state through flags; the block turns those flags, the read strobe and the region bits of the read address into the status bits on the data bus and a ready/busy level. When nothing is running and the read does not fall in a suspended region, the array word supplied by the read path passes through unchanged.

Several status bits are built at once, each under its own rule: a polling bit that shows the complement of the data being written (or 0 during an erase), a toggle bit that inverts on every read access while busy, a second toggle bit that marks the region held in erase suspend, a buffer-abort flag, and a fixed-length hold of busy status after an operation aimed at a protected region is refused. The two toggle bits are flip-flops that advance only on a read strobe, so a host that polls slowly sees the same alternation as one that polls fast.

Top module: `flash_stat_gen`

## Requirements
- R1: With no program, erase, abort or hold active and the read not in a suspended region, `rd_data` equals `array_word` and `ready` is 1.
- R2: While `pgm_busy` is 1 (and no buffer abort), bit 7 of `rd_data` is the inverse of `last_wr_msb`, and `ready` is 0. For a buffer program the caller supplies bit 7 of the last word loaded.
- R3: While `ers_busy` is 1 with no program or abort, bit 7 of `rd_data` is 0 and `ready` is 0; once `ers_busy` falls the word read is `array_word` again.
- R4: In any busy status mode bit 6 starts at 0 when the operation begins, inverts after every cycle with `rd_stb` high, keeps its value in cycles without `rd_stb`, and stops when the operation ends.
- R5: Bit 2 inverts after every read strobe during an erase and is 0 during a program; it is cleared when neither an erase nor a suspend is in force.
- R6: During erase suspend with no program running, a read whose `rd_region` equals `susp_region` returns bit 7 = 1, bit 6 = 1 and bit 2 toggling per read, with `ready` = 1.
- R7: During erase suspend, a read outside the suspended region returns `array_word` with `ready` = 1 and does not advance bit 2.
- R8: A program started during erase suspend gives program status (bit 6 toggling from 0, bit 2 = 0, `ready` = 0) at any read address, and suspend status resumes when it ends.
- R9: While `buf_abort` is 1 it overrides all other modes: bit 1 = 1, bit 7 = inverse of `last_wr_msb`, bit 6 toggling, `ready` = 0.
- R10: A one-cycle `prot_abort` pulse makes the status busy for exactly HOLD_CYC cycles starting the cycle after the pulse; bit 7 reads 0 if `prot_erase` was 1 and the inverse of `last_wr_msb` otherwise; afterwards the block returns to R1.
- R11: In every status mode the bits other than 7, 6, 2 and 1 read 0, and bit 1 is 0 unless `buf_abort` is 1.
- R12: After reset both toggle bits are 0 and no hold is pending, so the first status read of the first operation shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgm_busy | input | 1 | Program engine running |
| ers_busy | input | 1 | Erase engine running |
| ers_susp | input | 1 | An erase is held in suspend |
| susp_region | input | RW | Region index of the suspended erase |
| rd_region | input | RW | Region-select bits of the current read address |
| rd_stb | input | 1 | One cycle per host read access |
| last_wr_msb | input | 1 | Bit 7 of the word being programmed (last buffer word for buffer programs) |
| buf_abort | input | 1 | Buffer load or buffer program has aborted |
| prot_abort | input | 1 | Pulse: an operation targeted a protected region and was refused |
| prot_erase | input | 1 | With `prot_abort`: the refused operation was an erase |
| array_word | input | DW | Array data for the current read address |
| rd_data | output | DW | Word returned to the host |
| ready | output | 1 | 1 = read mode, 0 = busy |

## Verification
Program status is driven with the written bit 7 both 1 and 0, which separates a true complement from a constant, and erase status is read while `last_wr_msb` is 1 so a polling bit wrongly following the data shows up. Read sequences with gaps, and a stretch of busy cycles with no strobe, tell a toggle that advances per access from one that advances per clock. Suspend reads alternate between inside and outside the suspended region to show that only in-region reads move bit 2, and a program inside suspend shows the priority of program status. The abort hold is measured by counting busy cycles for both a program and an erase refusal, and the buffer abort is raised over a running program to show its override.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    M_ARRAY = 3'd0,
    M_SUSP  = 3'd1,
    M_HOLD  = 3'd2,
    M_ERASE = 3'd3,
    M_PROG  = 3'd4,
    M_ABORT = 3'd5
  } stat_mode_t;

  localparam int POLL_POS  = 7;
  localparam int TOG_POS   = 6;
  localparam int STOG_POS  = 2;
  localparam int ABORT_POS = 1;

  // Modes in which the device reports itself busy.
  function automatic logic mode_busy(input stat_mode_t m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_HOLD) || (m == M_ABORT);
  endfunction

  // Modes in which the region-toggle bit advances on a read.
  function automatic logic mode_region_tog(input stat_mode_t m);
    return (m == M_ERASE) || (m == M_SUSP);
  endfunction

  // Polling bit for each status mode.
  function automatic logic poll_value(input stat_mode_t m, input logic hold_erase,
                                      input logic wr_msb);
    logic v;
    v = 1'b0;
    case (m)
      M_PROG, M_ABORT: v = ~wr_msb;
      M_ERASE:         v = 1'b0;
      M_HOLD:          v = hold_erase ? 1'b0 : ~wr_msb;
      M_SUSP:          v = 1'b1;
      default:         v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/stat_mode_sel.sv
module stat_mode_sel
  import flash_stat_pkg::*;
(
  input  logic       buf_abort,
  input  logic       pgm_busy,
  input  logic       ers_busy,
  input  logic       hold_act,
  input  logic       in_susp,
  output stat_mode_t mode
);

  // Fixed priority: abort, program, erase, refusal hold, suspended read.
  always_comb begin
    if (buf_abort)     mode = M_ABORT;
    else if (pgm_busy) mode = M_PROG;
    else if (ers_busy) mode = M_ERASE;
    else if (hold_act) mode = M_HOLD;
    else if (in_susp)  mode = M_SUSP;
    else               mode = M_ARRAY;
  end

endmodule

// File: rtl/stat_tog_cell.sv
module stat_tog_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (adv) q <= ~q;
  end

  p_flip_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (q != $past(q)));

  p_steady_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(q));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);

endmodule

// File: rtl/stat_abort_hold.sv
module stat_abort_hold #(
  parameter int HOLD_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic trig_erase,
  output logic active,
  output logic kind_erase
);

  localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      kind_erase <= 1'b0;
    end else if (trig) begin
      cnt        <= LOAD;
      kind_erase <= trig_erase;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign active = (cnt != '0);

  // Checker: length of the run of active cycles since the last trigger.
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                run_len <= '0;
    else if (trig)                             run_len <= '0;
    else if (active && (run_len != '1))        run_len <= run_len + 1'b1;
    else if (!active)                          run_len <= '0;
  end

  p_hold_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> active);

  p_hold_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (run_len < (CNT_W+1)'(HOLD_CYC)));

endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import flash_stat_pkg::*;
#(
  parameter int DW       = 16,
  parameter int RW       = 10,
  parameter int HOLD_CYC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_busy,
  input  logic          ers_busy,
  input  logic          ers_susp,
  input  logic [RW-1:0] susp_region,
  input  logic [RW-1:0] rd_region,
  input  logic          rd_stb,
  input  logic          last_wr_msb,
  input  logic          buf_abort,
  input  logic          prot_abort,
  input  logic          prot_erase,
  input  logic [DW-1:0] array_word,
  output logic [DW-1:0] rd_data,
  output logic          ready
);

  stat_mode_t mode;
  logic       in_susp;
  logic       hold_act;
  logic       hold_erase;
  logic       status_busy;
  logic       tog_q [2];
  logic       tog_adv [2];
  logic       tog_clr [2];

  assign in_susp = ers_susp && (rd_region == susp_region);

  stat_abort_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (prot_abort),
    .trig_erase (prot_erase),
    .active     (hold_act),
    .kind_erase (hold_erase)
  );

  stat_mode_sel u_sel (
    .buf_abort (buf_abort),
    .pgm_busy  (pgm_busy),
    .ers_busy  (ers_busy),
    .hold_act  (hold_act),
    .in_susp   (in_susp),
    .mode      (mode)
  );

  assign status_busy = mode_busy(mode);

  // Index 0: operation toggle, index 1: suspended-region toggle.
  assign tog_adv[0] = rd_stb && status_busy;
  assign tog_clr[0] = !status_busy;
  assign tog_adv[1] = rd_stb && mode_region_tog(mode);
  assign tog_clr[1] = !(ers_busy || ers_susp);

  for (genvar g = 0; g < 2; g++) begin : g_tog
    stat_tog_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (tog_adv[g]),
      .clr   (tog_clr[g]),
      .q     (tog_q[g])
    );
  end

  always_comb begin
    if (mode == M_ARRAY) begin
      rd_data = array_word;
    end else begin
      rd_data            = '0;
      rd_data[POLL_POS]  = poll_value(mode, hold_erase, last_wr_msb);
      rd_data[TOG_POS]   = (mode == M_SUSP) ? 1'b1 : tog_q[0];
      rd_data[STOG_POS]  = mode_region_tog(mode) ? tog_q[1] : 1'b0;
      rd_data[ABORT_POS] = buf_abort;
    end
  end

  assign ready = !status_busy;

  p_array_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_busy && !ers_busy && !buf_abort && !hold_act && !in_susp)
      |-> (rd_data == array_word && ready));

  p_busy_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_busy || ers_busy) |-> !ready);

  p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_busy && !pgm_busy && !buf_abort) |-> !rd_data[POLL_POS]);

  p_susp_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_susp && !pgm_busy && !ers_busy && !buf_abort && !hold_act)
      |-> (rd_data[POLL_POS] && rd_data[TOG_POS] && ready));

  p_abort_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_abort |-> (rd_data[ABORT_POS] && !ready));

endmodule

// File: tb/flash_stat_gen_bench.sv
module flash_stat_gen_bench;

  localparam int DW = 16;
  localparam int RW = 10;
  localparam int HOLD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pgm_busy = 1'b0, ers_busy = 1'b0, ers_susp = 1'b0;
  logic [RW-1:0] susp_region = '0, rd_region = '0;
  logic          rd_stb = 1'b0, last_wr_msb = 1'b0, buf_abort = 1'b0;
  logic          prot_abort = 1'b0, prot_erase = 1'b0;
  logic [DW-1:0] array_word = '0;
  logic [DW-1:0] rd_data;
  logic          ready;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flash_stat_gen #(.DW(DW), .RW(RW), .HOLD_CYC(HOLD)) u_flash_stat_gen (
    .clk(clk), .rst_n(rst_n), .pgm_busy(pgm_busy), .ers_busy(ers_busy),
    .ers_susp(ers_susp), .susp_region(susp_region), .rd_region(rd_region),
    .rd_stb(rd_stb), .last_wr_msb(last_wr_msb), .buf_abort(buf_abort),
    .prot_abort(prot_abort), .prot_erase(prot_erase), .array_word(array_word),
    .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One read access: strobe for one cycle, sample the word it returns.
  task automatic rd(input string req, input logic [DW-1:0] exp_w, input logic exp_rdy);
    @(negedge clk);
    rd_stb = 1'b1;
    #2;
    chk(req, {ready, rd_data}, {exp_rdy, exp_w});
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset;
    array_word = 16'hA5C3;
    @(negedge clk); #2;
    chk("R12 reset idle word", {ready, rd_data}, {1'b1, 16'hA5C3});
    rd("R1 idle pass A", 16'hA5C3, 1'b1);
    array_word = 16'h5A3C;
    rd("R1 idle pass B", 16'h5A3C, 1'b1);
  endtask

  task automatic t_program;
    @(negedge clk); pgm_busy = 1'b1; last_wr_msb = 1'b1;
    rd("R12 R2 first program read", 16'h0000, 1'b0);
    rd("R4 program toggle", 16'h0040, 1'b0);
    rd("R11 R5 program toggle back", 16'h0000, 1'b0);
    @(negedge clk); pgm_busy = 1'b0; array_word = 16'h1357;
    rd("R4 program done", 16'h1357, 1'b1);
    @(negedge clk); pgm_busy = 1'b1; last_wr_msb = 1'b0;
    rd("R2 complement of 0", 16'h0080, 1'b0);
    // R4: no strobe for several cycles, toggle must hold
    repeat (5) @(negedge clk);
    rd("R4 no toggle without read", 16'h00C0, 1'b0);
    rd("R4 toggle after read", 16'h0080, 1'b0);
    @(negedge clk); pgm_busy = 1'b0;
  endtask

  task automatic t_erase;
    @(negedge clk); ers_busy = 1'b1; last_wr_msb = 1'b1; array_word = 16'hFFFF;
    rd("R3 erase poll 0", 16'h0000, 1'b0);
    rd("R5 erase both toggles", 16'h0044, 1'b0);
    rd("R5 erase toggles back", 16'h0000, 1'b0);
    @(negedge clk); ers_busy = 1'b0;
    rd("R3 erase done array", 16'hFFFF, 1'b1);
  endtask

  task automatic t_suspend;
    @(negedge clk); ers_busy = 1'b1;
    rd("R5 erase pre-suspend", 16'h0000, 1'b0);
    @(negedge clk); ers_busy = 1'b0; ers_susp = 1'b1; susp_region = 10'h005;
    rd_region = 10'h005; array_word = 16'h2468;
    rd("R6 suspended read 1", 16'h00C4, 1'b1);
    rd("R6 suspended read 2", 16'h00C0, 1'b1);
    rd_region = 10'h006;
    rd("R7 outside region", 16'h2468, 1'b1);
    rd_region = 10'h005;
    rd("R7 region toggle untouched", 16'h00C4, 1'b1);
  endtask

  task automatic t_prog_in_suspend;
    @(negedge clk); pgm_busy = 1'b1; last_wr_msb = 1'b0; rd_region = 10'h006;
    rd("R8 program in suspend", 16'h0080, 1'b0);
    rd_region = 10'h005;
    rd("R8 program toggles", 16'h00C0, 1'b0);
    @(negedge clk); pgm_busy = 1'b0;
    rd("R8 suspend status back", 16'h00C0, 1'b1);
    @(negedge clk); ers_susp = 1'b0;
    rd("R1 after suspend exit", 16'h2468, 1'b1);
  endtask

  task automatic t_buf_abort;
    @(negedge clk); pgm_busy = 1'b1; buf_abort = 1'b1; last_wr_msb = 1'b1;
    rd("R9 abort flag", 16'h0002, 1'b0);
    rd("R9 abort toggles", 16'h0042, 1'b0);
    @(negedge clk); buf_abort = 1'b0; pgm_busy = 1'b0;
    rd("R11 abort cleared", 16'h2468, 1'b1);
  endtask

  task automatic t_hold(input logic kind_erase, input logic [DW-1:0] exp_first);
    int lows;
    @(negedge clk); prot_abort = 1'b1; prot_erase = kind_erase; last_wr_msb = 1'b0;
    @(negedge clk); prot_abort = 1'b0; #2;
    chk("R10 hold first word", {ready, rd_data}, {1'b0, exp_first});
    lows = (ready == 1'b0) ? 1 : 0;
    for (int i = 0; i < 2 * HOLD; i++) begin
      @(negedge clk); #2;
      if (ready == 1'b0) lows++;
    end
    chk("R10 hold length", 17'(lows), 17'(HOLD));
    chk("R10 back to read", {ready, rd_data}, {1'b1, array_word});
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_prog_in_suspend();
    t_buf_abort();
    t_hold(1'b0, 16'h0080);
    t_hold(1'b1, 16'h0000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule